// File: doc/BRIEF.md
# Busy-Flag Gated Stage Controller

This block steers data through a short chain of stages, each of which can report through a status flag that it is still working. A word that arrives on the input is first taken into a pre-processing register. On each stage enable pulse, the flag of the main stage decides where that word goes. When the flag is 0 the word moves into the main stage. When the flag is 1 the word is parked in a one-entry delay holder until the main stage is free again. The main stage here is a pass-through register that stands in for the filter arithmetic.

Stage timing comes from a toggle flip-flop divider that runs on the single system clock and produces clock-enable pulses. No clock is gated. While the flag is 0, the stages advance at the slow rate, once every 2^DIV_W cycles. While the flag is 1, a multiplexer switches the stages to the rate one divider step up, twice as fast, so the upstream side keeps working while the main stage is busy. A small control unit produces three signals. It pulses the cell-memory clear when the block is enabled. It indicates the operating mode, normal or fast. It reports which source, pre-processing register or delay holder, feeds the main stage.

Top module: `sfc_stage_ctrl`

## Requirements
- R1: While rst_ni is low, out_valid_o, clr_o and sel_o are 0. After reset, both the pre-processing register and the delay holder are empty.
- R2: While en_i is 0, tick_o stays 0. While en_i is 1 and busy_i is 0, tick_o pulses once every 2^DIV_W cycles (4 by default). While en_i is 1 and busy_i is 1, it pulses once every 2^(DIV_W-1) cycles (2 by default).
- R3: mode_o is 1 (fast mode) exactly when en_i and busy_i are both 1. Otherwise it is 0 (normal mode).
- R4: clr_o is high for exactly one cycle, in the cycle that follows the first clock edge at which en_i is seen high after having been low.
- R5: in_ready_o is 1 only during a tick_o cycle in which the pre-processing register is empty or is handing its word on. A word is taken on a clock edge where in_valid_i and in_ready_o are both 1.
- R6: On a tick with busy_i at 0, the main stage takes the held word if the delay holder is occupied, and otherwise takes the pre-processing word. out_valid_o is then 1 for one cycle, with the word on out_data_o.
- R7: On a tick with busy_i at 1, nothing leaves the block. A pre-processing word moves into the delay holder if the holder is empty.
- R8: While busy_i stays 1 and both the pre-processing register and the delay holder are occupied, in_ready_o stays 0. No word is overwritten.
- R9: Words leave in the order they were accepted, with no drop and no duplicate, under any pattern of busy_i.
- R10: sel_o is 1 (delay holder feeds the main stage) exactly while the delay holder is occupied. It is 0 (pre-processing register feeds the main stage) otherwise. The holder empties only by handing its word to the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; starts the divider |
| busy_i | input | 1 | Main-stage status flag: 1 busy, 0 ready |
| in_valid_i | input | 1 | Input word present |
| in_data_i | input | DW | Input word |
| in_ready_o | output | 1 | Input word taken at this edge if valid |
| out_valid_o | output | 1 | Main stage holds a new word |
| out_data_o | output | DW | Main-stage word |
| tick_o | output | 1 | Selected stage enable pulse |
| sel_o | output | 1 | Main-stage input select: 1 delay holder, 0 pre-processing |
| clr_o | output | 1 | Cell-memory clear pulse |
| mode_o | output | 1 | Operating mode: 1 fast, 0 normal |

## Verification
Some rules are checked by properties on every cycle. An output word must follow a tick on which the flag was 0. Input acceptance only happens on a tick. There are no ticks while disabled. The clear is a single cycle long. The delay holder can empty only by delivering its word. Other behaviour needs the bench's scenarios because it depends on sequences. These are the exact tick spacing in each mode, the refusal of a third word during a stall, the hold-before-pre ordering once the flag drops, and the in-order, loss-free delivery under random flag patterns.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef enum logic {
    SRC_PRE  = 1'b0,
    SRC_HOLD = 1'b1
  } src_e;
endpackage

// File: rtl/sfc_rate_div.sv
module sfc_rate_div #(
  parameter int DIV_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic busy_i,
  output logic tick_o
);
  logic [DIV_W-1:0] tgl_q;
  logic [DIV_W:0]   carry;

  assign carry[0] = 1'b1;

  for (genvar k = 0; k < DIV_W; k++) begin : g_tff
    assign carry[k+1] = carry[k] & tgl_q[k];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       tgl_q[k] <= 1'b0;
      else if (!en_i)    tgl_q[k] <= 1'b0;
      else if (carry[k]) tgl_q[k] <= ~tgl_q[k];
    end
  end

  logic slow_tick, fast_tick;
  assign slow_tick = en_i & carry[DIV_W];
  assign fast_tick = en_i & carry[DIV_W-1];

  // flag picks the rate
  assign tick_o = busy_i ? fast_tick : slow_tick;
endmodule

// File: rtl/sfc_ctrl_unit.sv
module sfc_ctrl_unit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic busy_i,
  output logic clr_o,
  output logic mode_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      clr_o <= 1'b0;
    end else begin
      en_q  <= en_i;
      clr_o <= en_i & ~en_q;
    end
  end

  assign mode_o = en_i & busy_i;
endmodule

// File: rtl/sfc_path.sv
module sfc_path
  import sfc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          busy_i,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  output logic          in_ready_o,
  output logic          out_valid_o,
  output logic [DW-1:0] out_data_o,
  output src_e          src_o
);
  logic          pre_vld, hold_vld;
  logic [DW-1:0] pre_dat, hold_dat;
  logic          pre_moves, take, accept;

  // pre hands on whenever holder is free: to main stage or into holder
  assign pre_moves  = pre_vld & ~hold_vld;
  assign take       = tick_i & ~busy_i & (hold_vld | pre_vld);
  assign in_ready_o = tick_i & (~pre_vld | pre_moves);
  assign accept     = in_valid_i & in_ready_o;
  assign src_o      = hold_vld ? SRC_HOLD : SRC_PRE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= take;
      if (take) out_data_o <= hold_vld ? hold_dat : pre_dat;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_vld <= 1'b0;
      hold_dat <= '0;
    end else if (tick_i) begin
      if (hold_vld && !busy_i) begin
        hold_vld <= 1'b0;
      end else if (!hold_vld && busy_i && pre_vld) begin
        hold_vld <= 1'b1;
        hold_dat <= pre_dat;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_vld <= 1'b0;
      pre_dat <= '0;
    end else if (accept) begin
      pre_vld <= 1'b1;
      pre_dat <= in_data_i;
    end else if (tick_i && pre_moves) begin
      pre_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/sfc_stage_ctrl.sv
module sfc_stage_ctrl
  import sfc_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DIV_W = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          busy_i,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  output logic          in_ready_o,
  output logic          out_valid_o,
  output logic [DW-1:0] out_data_o,
  output logic          tick_o,
  output logic          sel_o,
  output logic          clr_o,
  output logic          mode_o
);
  src_e src;

  sfc_rate_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .busy_i (busy_i),
    .tick_o (tick_o)
  );

  sfc_ctrl_unit u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .busy_i (busy_i),
    .clr_o  (clr_o),
    .mode_o (mode_o)
  );

  sfc_path #(.DW(DW)) u_path (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_o),
    .busy_i      (busy_i),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .src_o       (src)
  );

  assign sel_o = (src == SRC_HOLD);
endmodule

// File: rtl/sfc_stage_ctrl_chk.sv
module sfc_stage_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic busy_i,
  input logic in_ready_o,
  input logic out_valid_o,
  input logic tick_o,
  input logic sel_o,
  input logic clr_o
);
  always_comb begin
    if (!rst_ni) begin
      a_reset_outs_r1: assert (!out_valid_o && !clr_o && !sel_o);
    end
  end

  p_no_tick_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !tick_o);

  p_clr_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> !clr_o);

  p_ready_on_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> tick_o);

  p_out_after_free_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(tick_o && !busy_i));

  p_hold_drains_out_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sel_o) |-> out_valid_o);
endmodule

bind sfc_stage_ctrl sfc_stage_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .busy_i      (busy_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .tick_o      (tick_o),
  .sel_o       (sel_o),
  .clr_o       (clr_o)
);

// File: tb/sfc_stage_ctrl_test.sv
module sfc_stage_ctrl_test;
  localparam int CLK_P = 10;
  localparam int DW    = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en_i = 1'b0, busy_i = 1'b0, in_valid_i = 1'b0;
  logic [DW-1:0] in_data_i = '0;
  logic          in_ready_o, out_valid_o, tick_o, sel_o, clr_o, mode_o;
  logic [DW-1:0] out_data_o;

  int checks = 0, bad = 0;
  int outs = 0;
  logic [DW-1:0] next_send = '0, next_exp = '0;
  logic [15:0]   lfsr = 16'hACE1;

  always #(CLK_P/2) clk_i = ~clk_i;

  sfc_stage_ctrl #(.DW(DW), .DIV_W(2)) uut (
    .clk_i, .rst_ni, .en_i, .busy_i, .in_valid_i, .in_data_i,
    .in_ready_o, .out_valid_o, .out_data_o, .tick_o, .sel_o, .clr_o, .mode_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R9 monitor: every output word must be the next one sent
  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o) begin
      chk(out_data_o == next_exp, "R9 order", out_data_o, next_exp);
      next_exp = next_exp + 1'b1;
      outs++;
    end
  end

  task automatic drive_items(input int n, input int bmode, input int max_cyc, output int acc);
    acc = 0;
    for (int c = 0; c < max_cyc && acc < n; c++) begin
      @(negedge clk_i);
      if (bmode == 1) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        busy_i = lfsr[0];
      end else busy_i = (bmode == 2);
      in_valid_i = 1'b1;
      in_data_i  = next_send;
      #1;
      if (in_ready_o) begin
        acc++;
        next_send = next_send + 1'b1;
      end
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
    busy_i = (bmode == 2);
  endtask

  task automatic drain(input int cyc);
    busy_i = 1'b0;
    in_valid_i = 1'b0;
    repeat (cyc) @(negedge clk_i);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    chk(!out_valid_o, "R1 out_valid in reset", out_valid_o, 0);
    chk(!clr_o, "R1 clr in reset", clr_o, 0);
    chk(!sel_o, "R1 sel in reset", sel_o, 0);
    rst_ni = 1'b1;
    begin
      int n = 0;
      for (int i = 0; i < 8; i++) begin @(negedge clk_i); n += tick_o; end
      chk(n == 0, "R2 no tick while disabled", n, 0);
    end
  endtask

  task automatic t_clr();
    en_i = 1'b1;
    @(negedge clk_i);
    chk(clr_o, "R4 clr after enable", clr_o, 1);
    @(negedge clk_i);
    chk(!clr_o, "R4 clr one cycle", clr_o, 0);
  endtask

  task automatic t_rates_mode();
    int n;
    busy_i = 1'b0;
    n = 0;
    for (int i = 0; i < 16; i++) begin @(negedge clk_i); #1; n += tick_o; end
    chk(n == 4, "R2 normal rate", n, 4);
    chk(!mode_o, "R3 normal mode", mode_o, 0);
    busy_i = 1'b1;
    #1;
    chk(mode_o, "R3 fast mode", mode_o, 1);
    n = 0;
    for (int i = 0; i < 16; i++) begin @(negedge clk_i); #1; n += tick_o; end
    chk(n == 8, "R2 fast rate", n, 8);
    en_i = 1'b0;
    #1;
    chk(!mode_o, "R3 mode off when disabled", mode_o, 0);
    @(negedge clk_i);
    en_i = 1'b1;
    busy_i = 1'b0;
    @(negedge clk_i);
    chk(clr_o, "R4 clr on re-enable", clr_o, 1);
  endtask

  task automatic t_free_flow();
    int acc, o0;
    o0 = outs;
    drive_items(10, 0, 200, acc);
    chk(acc == 10, "R5 accepted free flow", acc, 10);
    drain(12);
    chk(outs - o0 == 10, "R6 outputs free flow", outs - o0, 10);
  endtask

  task automatic t_stall();
    int acc, o0, rdy;
    o0 = outs;
    drive_items(3, 2, 24, acc);
    chk(acc == 2, "R8 only two taken while stalled", acc, 2);
    chk(sel_o, "R10 holder occupied", sel_o, 1);
    chk(outs == o0, "R7 no output while busy", outs - o0, 0);
    rdy = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk_i); #1; rdy += in_ready_o; end
    chk(rdy == 0, "R8 ready low when full", rdy, 0);
    drain(16);
    chk(outs - o0 == 2, "R6 stalled words released", outs - o0, 2);
    chk(!sel_o, "R10 holder empty after release", sel_o, 0);
  endtask

  task automatic t_random();
    int acc, o0;
    o0 = outs;
    drive_items(60, 1, 3000, acc);
    chk(acc == 60, "R5 accepted random", acc, 60);
    drain(24);
    chk(outs - o0 == 60, "R9 no drop random", outs - o0, 60);
    chk(next_exp == next_send, "R9 counts match", next_exp, next_send);
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_clr();
    t_rates_mode();
    t_free_flow();
    t_stall();
    t_random();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule